// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Fault Hold-Off

This block is the digital gate-control logic for one full bridge of a motor driver. It takes an enable, two leg-select inputs and two fault flags (overcurrent and over-temperature). It produces the four gate commands of the bridge: a high-side and a low-side switch for each of the two legs. It also produces a request that pulls the bridge's own enable line low. Leg 0 drives the first output terminal and follows `in1_i`. Leg 1 drives the second terminal and follows `in2_i`. A select input at 1 asks for the leg's high-side switch (output to supply). At 0 it asks for the low-side switch (output to ground).

Every asynchronous input passes through a two-flop synchronizer before it is decoded. A leg never turns a switch on the moment its target changes. It first turns off whatever is on, then waits a dead-time window of `DEAD_CYC` clock cycles, and only then turns on the new switch. When either fault flag is seen, the block asserts its enable pull-down and keeps the bridge off for `OFF_CYC` cycles. It re-arms only once that window has expired and both flags are clear. While the pull-down is active the external enable has no effect.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: While the synchronized enable is 0, all four gate outputs are 0, whatever `in1_i` and `in2_i` are.
- R2: With enable 1 and both select inputs 0, both low-side gates (`gate_ls_o` = 2'b11) are on and both high-side gates are off, once settled.
- R3: With enable 1, `in1_i`=1 and `in2_i`=0 give `gate_hs_o`=2'b01 and `gate_ls_o`=2'b10. `in1_i`=0 and `in2_i`=1 give `gate_hs_o`=2'b10 and `gate_ls_o`=2'b01. Bit 0 is leg 0.
- R4: With enable 1 and both select inputs 1, both high-side gates (`gate_hs_o`=2'b11) are on and both low-side gates are off.
- R5: The high-side and low-side gates of one leg are never 1 in the same cycle.
- R6: When a leg's target changes, the switch that is on turns off at once. The new switch turns on exactly `DEAD_CYC` cycles later, so the leg shows both gates off for `DEAD_CYC` cycles.
- R7: If a leg's target changes again while its dead-time window runs, the window restarts from that change. For a re-change three cycles after the first, the leg shows `DEAD_CYC`+3 cycles with both gates off before the final switch turns on.
- R8: An overcurrent flag raises `en_pull_o` and forces all gates off from the next cycle. For a fault that clears early, `en_pull_o` stays high for exactly `OFF_CYC` cycles.
- R9: The over-temperature flag trips the same hold-off path with the same `OFF_CYC` window.
- R10: During the hold-off the external enable is ignored. Re-arming needs both the expired window and clear flags. A fault held for H ≥ `OFF_CYC` cycles keeps `en_pull_o` high for H cycles. After re-arm, the decoded state returns after a dead time.
- R11: An input change first affects the gates at the third rising clock edge after it is applied. Select inputs toggled with a half-period longer than the dead time lose no transition: every high pulse of `in1_i` gives one rising edge of `gate_hs_o[0]`.
- R12: During and right after reset, all gates are off and `en_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Bridge enable, asynchronous |
| in1_i | input | 1 | Leg 0 select (1 = supply, 0 = ground), asynchronous |
| in2_i | input | 1 | Leg 1 select (1 = supply, 0 = ground), asynchronous |
| ocp_i | input | 1 | Overcurrent flag, asynchronous |
| otp_i | input | 1 | Over-temperature flag, asynchronous |
| gate_hs_o | output | 2 | High-side gate commands, bit n for leg n |
| gate_ls_o | output | 2 | Low-side gate commands, bit n for leg n |
| en_pull_o | output | 1 | Enable pull-down request, high during hold-off |

## Verification
A leg whose dead-time counter or remembered target is wrong shows up at its own gate pins. Either the off gap before the new switch differs from `DEAD_CYC`, or a switch turns on while the target is still moving, within one dead-time window of the change. A wrong hold-off counter or state shows up on `en_pull_o`: the high window comes out shorter or longer than `OFF_CYC`, or the pin falls while a flag is still present. Gates that come back while the pin is high show up one cycle after the pull-down. Synchronizer depth errors move every response by a whole cycle, so they are caught at the first input change by sampling the second and third cycles after it.

// File: rtl/hbg_pkg.sv
// Shared types for the full-bridge gate sequencer.
// Assumes: two legs per bridge; targets are mutually exclusive per leg.
package hbg_pkg;

    localparam int unsigned NUM_LEGS = 2;

    // Requested switch for one leg.
    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_LOW  = 2'b01,
        LEG_HIGH = 2'b10
    } leg_tgt_e;

    // Fault hold-off state.
    typedef enum logic {
        FLT_ARMED = 1'b0,
        FLT_HOLD  = 1'b1
    } flt_state_e;

endpackage

// File: rtl/hbg_sync.sv
// Multi-stage synchronizer for a vector of asynchronous level inputs.
// Assumes: each bit is a slow level; bits are not related to each other.
module hbg_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the flop chain; all stages clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hbg_fault_timer.sv
// Fault hold-off timer: on any synchronized fault it enters a hold state
// for OFF_CYC cycles and leaves only when the window has expired and the
// fault is clear. The hold output is the enable pull-down request.
// Assumes: fault_i is already synchronized; OFF_CYC >= 1.
module hbg_fault_timer
    import hbg_pkg::*;
#(
    parameter int unsigned OFF_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_i,
    output logic hold_o
);

    localparam int unsigned CW = $clog2(OFF_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(OFF_CYC - 1);

    flt_state_e    state;
    logic [CW-1:0] cnt;

    // Arm/hold sequencing with the off-window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FLT_ARMED;
            cnt   <= '0;
        end else begin
            case (state)
                FLT_ARMED: begin
                    if (fault_i) begin
                        state <= FLT_HOLD;
                        cnt   <= LOAD;
                    end
                end
                FLT_HOLD: begin
                    if (cnt != '0)     cnt   <= cnt - 1'b1;
                    else if (!fault_i) state <= FLT_ARMED;
                end
                default: state <= FLT_ARMED;
            endcase
        end
    end

    assign hold_o = (state == FLT_HOLD);

endmodule

// File: rtl/hbg_leg_driver.sv
// One bridge leg: break-before-make sequencing with a dead-time window.
// A switch that no longer matches the target is dropped at once; the new
// switch turns on DEAD_CYC cycles after the target last changed.
// Assumes: tgt_i is glitch-free per clock (driven from registers); DEAD_CYC >= 1.
module hbg_leg_driver
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 200
) (
    input  logic     clk,
    input  logic     rst_n,
    input  leg_tgt_e tgt_i,
    output logic     hs_o,
    output logic     ls_o
);

    localparam int unsigned CW = $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC - 1);

    logic          hs_q, ls_q;
    logic [CW-1:0] cnt;
    leg_tgt_e      tgt_q;
    logic          drop_on, idle, retarget;

    // Classify the current cycle: drop a stale switch, or wait while idle.
    always_comb begin
        drop_on  = (hs_q && (tgt_i != LEG_HIGH)) || (ls_q && (tgt_i != LEG_LOW));
        idle     = !hs_q && !ls_q;
        retarget = (tgt_i != tgt_q);
    end

    // Gate registers, dead-time countdown and remembered target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q  <= 1'b0;
            ls_q  <= 1'b0;
            cnt   <= LOAD;
            tgt_q <= LEG_OFF;
        end else begin
            tgt_q <= tgt_i;
            if (drop_on) begin
                hs_q <= 1'b0;
                ls_q <= 1'b0;
                cnt  <= LOAD;
            end else if (idle) begin
                if (retarget)        cnt <= LOAD;
                else if (cnt != '0)  cnt <= cnt - 1'b1;
                else begin
                    hs_q <= (tgt_i == LEG_HIGH);
                    ls_q <= (tgt_i == LEG_LOW);
                end
            end
        end
    end

    assign hs_o = hs_q;
    assign ls_o = ls_q;

endmodule

// File: rtl/hbridge_gate_ctrl.sv
// Full-bridge gate sequencer: synchronizes the control and fault inputs,
// decodes the per-leg targets, runs one dead-time driver per leg and a
// fault hold-off timer that also raises the enable pull-down request.
// Assumes: one clock domain; DEAD_CYC and OFF_CYC are in clock cycles.
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned DEAD_CYC    = 200,
    parameter int unsigned OFF_CYC     = 2000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       in1_i,
    input  logic       in2_i,
    input  logic       ocp_i,
    input  logic       otp_i,
    output logic [1:0] gate_hs_o,
    output logic [1:0] gate_ls_o,
    output logic       en_pull_o
);

    localparam int unsigned SW = NUM_LEGS + 3;

    logic [SW-1:0]       raw, syn;
    logic [NUM_LEGS-1:0] dir_s;
    logic                en_s, flt_s, hold;
    leg_tgt_e            tgt [NUM_LEGS];

    assign raw = {otp_i, ocp_i, en_i, in2_i, in1_i};

    hbg_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  (raw),
        .q_o  (syn)
    );

    assign dir_s = syn[NUM_LEGS-1:0];
    assign en_s  = syn[NUM_LEGS];
    assign flt_s = syn[NUM_LEGS+1] | syn[NUM_LEGS+2];

    hbg_fault_timer #(.OFF_CYC(OFF_CYC)) u_flt (
        .clk    (clk),
        .rst_n  (rst_n),
        .fault_i(flt_s),
        .hold_o (hold)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_LEGS; g++) begin : g_leg
            // Decode the leg target from enable, hold-off and select bit.
            always_comb begin
                if (hold || !en_s) tgt[g] = LEG_OFF;
                else if (dir_s[g]) tgt[g] = LEG_HIGH;
                else               tgt[g] = LEG_LOW;
            end

            hbg_leg_driver #(.DEAD_CYC(DEAD_CYC)) u_leg (
                .clk  (clk),
                .rst_n(rst_n),
                .tgt_i(tgt[g]),
                .hs_o (gate_hs_o[g]),
                .ls_o (gate_ls_o[g])
            );
        end
    endgenerate

    assign en_pull_o = hold;

endmodule

// File: rtl/hbg_checker.sv
// Property checker for the full-bridge gate sequencer, bound to the top.
// Assumes: the default two synchronizer stages.
module hbg_checker #(
    parameter int unsigned DEAD_CYC = 200,
    parameter int unsigned OFF_CYC  = 2000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_i,
    input logic [1:0] gate_hs_o,
    input logic [1:0] gate_ls_o,
    input logic       en_pull_o
);

    localparam int unsigned DW = $clog2(DEAD_CYC + 1);
    localparam int unsigned PW = $clog2(OFF_CYC + 1);

    logic [PW-1:0] pull_run;

    // Count consecutive cycles with the pull-down active (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !en_pull_o)       pull_run <= '0;
        else if (pull_run != PW'(OFF_CYC)) pull_run <= pull_run + 1'b1;
    end

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_leg
            logic [DW-1:0] off_run;

            // Count consecutive cycles with both gates of this leg off.
            always_ff @(posedge clk) begin
                if (!rst_n || gate_hs_o[g] || gate_ls_o[g]) off_run <= '0;
                else if (off_run != DW'(DEAD_CYC))          off_run <= off_run + 1'b1;
            end

            a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
                !(gate_hs_o[g] && gate_ls_o[g]));

            a_r6_dead_gap: assert property (@(posedge clk) disable iff (!rst_n)
                ($rose(gate_hs_o[g]) || $rose(gate_ls_o[g])) |-> (off_run >= DW'(DEAD_CYC)));
        end
    endgenerate

    a_r1_enable_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i, 3) |-> (gate_hs_o == 2'b00 && gate_ls_o == 2'b00));

    a_r8_pull_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        en_pull_o |=> (gate_hs_o == 2'b00 && gate_ls_o == 2'b00));

    a_r10_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_pull_o) |-> (pull_run >= PW'(OFF_CYC)));

endmodule

bind hbridge_gate_ctrl hbg_checker #(.DEAD_CYC(DEAD_CYC), .OFF_CYC(OFF_CYC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .gate_hs_o(gate_hs_o),
    .gate_ls_o(gate_ls_o),
    .en_pull_o(en_pull_o)
);

// File: tb/sim_hbridge_gate_ctrl.sv
// Scoreboard bench for the full-bridge gate sequencer.
module sim_hbridge_gate_ctrl;

    localparam int D   = 8;
    localparam int OFF = 40;
    localparam int SET = D + 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_i = 1'b0, in1_i = 1'b0, in2_i = 1'b0, ocp_i = 1'b0, otp_i = 1'b0;
    logic [1:0] gate_hs_o, gate_ls_o;
    logic       en_pull_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0] hs;
        logic [1:0] ls;
        logic       pull;
        int         wt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    hbridge_gate_ctrl #(.DEAD_CYC(D), .OFF_CYC(OFF)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_i),
        .in1_i    (in1_i),
        .in2_i    (in2_i),
        .ocp_i    (ocp_i),
        .otp_i    (otp_i),
        .gate_hs_o(gate_hs_o),
        .gate_ls_o(gate_ls_o),
        .en_pull_o(en_pull_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, expv);
        end
    endtask

    // Driver: apply inputs and push the settled expectation.
    task automatic drive(input logic e, input logic a, input logic b,
                         input logic [1:0] hs, input logic [1:0] ls, input logic p,
                         input string tag);
        exp_t it;
        @(negedge clk);
        en_i = e; in1_i = a; in2_i = b;
        it.hs = hs; it.ls = ls; it.pull = p; it.wt = SET; it.tag = tag;
        exp_q.push_back(it);
        repeat (SET) @(negedge clk);
    endtask

    // Monitor: pop each expectation and compare once it has settled.
    initial begin
        forever begin
            exp_t it;
            wait (exp_q.size() != 0);
            it = exp_q.pop_front();
            repeat (it.wt) @(negedge clk);
            chk({en_pull_o, gate_hs_o, gate_ls_o} == {it.pull, it.hs, it.ls}, it.tag,
                int'({en_pull_o, gate_hs_o, gate_ls_o}), int'({it.pull, it.hs, it.ls}));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            summary();
            $finish;
        end
    end

    // Fault pulse on one flag; returns pull-high samples and gate-leak flag.
    task automatic fault_pulse(input bit use_otp, input int hold_cyc, input int win,
                               output int pulls, output bit leak, output bit mid_hi);
        bit prev = 1'b0;
        pulls = 0; leak = 1'b0; mid_hi = 1'b0;
        @(negedge clk);
        if (use_otp) otp_i = 1'b1; else ocp_i = 1'b1;
        for (int k = 0; k < win; k++) begin
            @(negedge clk);
            if (en_pull_o) pulls++;
            if (en_pull_o && prev && (gate_hs_o != 2'b00 || gate_ls_o != 2'b00)) leak = 1'b1;
            if (k == OFF + 10 && en_pull_o) mid_hi = 1'b1;
            prev = en_pull_o;
            if (k == hold_cyc - 1) begin ocp_i = 1'b0; otp_i = 1'b0; end
            if (k == 10) en_i = 1'b0;
            if (k == 20) en_i = 1'b1;
        end
    endtask

    initial begin
        int  offs, pulls, rises;
        bit  ovl, saw_hs, leak, mid_hi, prev;

        // R12: reset state
        repeat (4) @(negedge clk);
        chk({en_pull_o, gate_hs_o, gate_ls_o} == 5'b0, "R12 in reset",
            int'({en_pull_o, gate_hs_o, gate_ls_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({en_pull_o, gate_hs_o, gate_ls_o} == 5'b0, "R12 after reset",
            int'({en_pull_o, gate_hs_o, gate_ls_o}), 0);

        // Decode table through the scoreboard
        drive(1'b0, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, "R1 disabled 10");
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, "R2 both low");
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R3 in1 high");
        drive(1'b1, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0, "R3 in2 high");
        drive(1'b1, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, "R4 both high");
        drive(1'b0, 1'b1, 1'b1, 2'b00, 2'b00, 1'b0, "R1 disabled 11");

        // R6/R5: dead gap from low-side to high-side on leg 0
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, "R2 reentry");
        @(negedge clk);
        in1_i = 1'b1;
        offs = 0; ovl = 1'b0;
        for (int k = 0; k < 3 * D; k++) begin
            @(negedge clk);
            if (!gate_hs_o[0] && !gate_ls_o[0]) offs++;
            if ((gate_hs_o & gate_ls_o) != 2'b00) ovl = 1'b1;
        end
        chk(offs == D, "R6 dead gap", offs, D);
        chk(gate_hs_o[0] == 1'b1, "R6 new switch on", int'(gate_hs_o[0]), 1);
        chk(!ovl, "R5 no overlap", int'(ovl), 0);

        // R7: retarget during the dead window restarts it
        drive(1'b1, 1'b0, 1'b0, 2'b00, 2'b11, 1'b0, "R2 before restart");
        @(negedge clk);
        in1_i = 1'b1;
        offs = 0; saw_hs = 1'b0;
        for (int k = 0; k < 3 * D; k++) begin
            @(negedge clk);
            if (!gate_hs_o[0] && !gate_ls_o[0]) offs++;
            if (gate_hs_o[0]) saw_hs = 1'b1;
            if (k == 2) in1_i = 1'b0;
        end
        chk(offs == D + 3, "R7 restarted gap", offs, D + 3);
        chk(!saw_hs && gate_ls_o[0], "R7 final switch low", int'({saw_hs, gate_ls_o[0]}), 1);

        // R11: latency of three rising edges
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R3 before latency");
        @(negedge clk);
        in1_i = 1'b0;
        @(negedge clk);
        chk(gate_hs_o[0] == 1'b1, "R11 edge1 unchanged", int'(gate_hs_o[0]), 1);
        @(negedge clk);
        chk(gate_hs_o[0] == 1'b1, "R11 edge2 unchanged", int'(gate_hs_o[0]), 1);
        @(negedge clk);
        chk(gate_hs_o[0] == 1'b0, "R11 edge3 off", int'(gate_hs_o[0]), 0);
        repeat (SET) @(negedge clk);

        // R11: PWM on in1, every pulse seen
        rises = 0; prev = gate_hs_o[0];
        for (int p = 0; p < 5; p++) begin
            for (int k = 0; k < 2 * SET; k++) begin
                @(negedge clk);
                if (gate_hs_o[0] && !prev) rises++;
                prev = gate_hs_o[0];
                if (k == 0) in1_i = 1'b1;
                if (k == SET) in1_i = 1'b0;
            end
        end
        chk(rises == 5, "R11 pwm pulses", rises, 5);

        // R8: short overcurrent, en toggled during hold (R10)
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R3 before fault");
        fault_pulse(1'b0, 2, OFF + 20, pulls, leak, mid_hi);
        chk(pulls == OFF, "R8 pull window", pulls, OFF);
        chk(!leak, "R8 gates off in hold", int'(leak), 0);
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R10 recovered");

        // R9: over-temperature shares the path
        fault_pulse(1'b1, 2, OFF + 20, pulls, leak, mid_hi);
        chk(pulls == OFF, "R9 pull window", pulls, OFF);
        chk(!leak, "R9 gates off in hold", int'(leak), 0);
        drive(1'b1, 1'b1, 1'b0, 2'b01, 2'b10, 1'b0, "R9 recovered");

        // R10: fault held past the window keeps the pull-down
        fault_pulse(1'b0, OFF + 20, OFF + 40, pulls, leak, mid_hi);
        chk(pulls == OFF + 20, "R10 held fault", pulls, OFF + 20);
        chk(mid_hi, "R10 no early rearm", int'(mid_hi), 1);
        chk(!leak, "R10 gates off in hold", int'(leak), 0);
        drive(1'b1, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0, "R10 rearmed decode");

        repeat (2) @(negedge clk);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule